// File: doc/BRIEF.md
# Receive Buffer with Per-Byte Error Tags and Line/Modem Interrupts

This block sits between a serial receiver's deserializer and a host. Each received byte enters a circular buffer together with three error tags: parity, framing and break. The tags move through the buffer with their byte. The host therefore sees a byte's errors only when that byte reaches the read head. A line status word gives the head's tags, a sticky overrun bit, a data-ready bit and an error summary bit. The summary bit stays set while any tagged byte is still stored. A running count of tagged entries drives it, so the storage is never scanned.

Two interrupt lines go to the host. The line-status interrupt fires for a tagged head entry or for an overrun. Reading the status word clears it, and it re-arms when the head moves to another tagged entry. The modem-status interrupt fires on any change of the synchronized modem inputs. Reading the modem status word clears it. A programmable fill threshold drives a data-available output. With the buffer disabled, the block acts as a single holding register.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the buffer is empty, `lsr` reads 0, `rd_data` reads 0, and `irq_ls`, `irq_ms` and `data_avail` are low.
- R2: Bytes are read in the order they were written. `rd_data` shows the head byte, and `lsr[0]` (data ready) is 1 whenever at least one byte is stored. A `rd_data_stb` pulse removes the head.
- R3: `lsr[2]`, `lsr[3]` and `lsr[4]` show the parity, framing and break tags of the head entry. They read 0 when the buffer is empty.
- R4: Without an overrun, `irq_ls` is high only while the head entry carries a tag. Untagged entries at the head never raise it, even if tagged entries sit behind them.
- R5: A `lsr_rd_stb` pulse drops `irq_ls` on the next cycle. It stays low while the same head remains. It rises again when the head advances to another tagged entry.
- R6: `lsr[7]` is 1 exactly while at least one stored entry carries a tag.
- R7: A byte written while the buffer is full is discarded. `lsr[1]` (overrun) is then set and raises `irq_ls` until the next `lsr_rd_stb`.
- R8: With the buffer enabled, `data_avail` is high when the stored count is at least `trig_lvl`. A `trig_lvl` of 0 acts as 1.
- R9: With `fifo_en` low, capacity is one byte. A second write before a read overruns, and `data_avail` follows data ready.
- R10: A change on any `modem_in` bit latches the matching `msr[3:0]` bit and raises `irq_ms`. A `msr_rd_stb` clears the latched bits. `msr[7:4]` shows the synchronized inputs.
- R11: `irq_ls` is low while `ie_ls` is low, and `irq_ms` is low while `ie_ms` is low. The pending conditions are kept and appear once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Deserializer write strobe |
| wr_data | input | 8 | Received byte |
| wr_par_err | input | 1 | Parity error tag |
| wr_frm_err | input | 1 | Framing error tag |
| wr_brk | input | 1 | Break tag |
| fifo_en | input | 1 | 1: buffer of DEPTH, 0: single holding register |
| trig_lvl | input | AW+1 | Fill threshold for data_avail |
| ie_ls | input | 1 | Line-status interrupt enable |
| ie_ms | input | 1 | Modem-status interrupt enable |
| rd_data_stb | input | 1 | Host pops the head byte |
| lsr_rd_stb | input | 1 | Host reads the line status word |
| msr_rd_stb | input | 1 | Host reads the modem status word |
| modem_in | input | MW | Asynchronous modem control inputs |
| rd_data | output | 8 | Head byte |
| lsr | output | 8 | Line status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 7 error summary |
| msr | output | 2*MW | Modem status: change bits low, current inputs high |
| data_avail | output | 1 | Fill threshold reached |
| irq_ls | output | 1 | Line-status interrupt |
| irq_ms | output | 1 | Modem-status interrupt |

## Verification
The main pass loads a mix of clean bytes and bytes with one tag each, then pops them one at a time. It checks the data, the head tags, the interrupt and the summary bit at every step. This shows whether tags stay bound to their own byte, and whether the summary follows the remaining stored entries rather than the head alone. Directed sequences place a clean byte in front of tagged ones to test the interrupt re-arm. They also overfill in both capacity modes and step the fill threshold across its edge. The modem inputs are toggled with the enable off and on, to separate latching from gating.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 16,
  parameter int MW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          wr_par_err,
  input  logic          wr_frm_err,
  input  logic          wr_brk,
  input  logic          fifo_en,
  input  logic [CW-1:0] trig_lvl,
  input  logic          ie_ls,
  input  logic          ie_ms,
  input  logic          rd_data_stb,
  input  logic          lsr_rd_stb,
  input  logic          msr_rd_stb,
  input  logic [MW-1:0] modem_in,
  output logic [7:0]    rd_data,
  output logic [7:0]    lsr,
  output logic [2*MW-1:0] msr,
  output logic          data_avail,
  output logic          irq_ls,
  output logic          irq_ms
);
  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, ecnt;
  logic          ovr, ack;
  logic [MW-1:0] s1, s2, prv, dlt;

  wire [CW-1:0] cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          empty    = (cnt == '0);
  wire          full     = (cnt >= cap);
  wire          do_rd    = rd_data_stb && !empty;
  wire          do_wr    = wr_en && (!full || do_rd);
  wire [2:0]    wr_flags = {wr_brk, wr_frm_err, wr_par_err};
  wire [10:0]   head     = mem[rp];
  wire [2:0]    hflags   = empty ? 3'b000 : head[10:8];
  wire          head_err = |hflags;
  wire [CW-1:0] trig_eff = (trig_lvl == '0) ? CW'(1) : trig_lvl;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= {wr_flags, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
      ovr  <= 1'b0;
      ack  <= 1'b0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt  <= cnt + CW'(do_wr) - CW'(do_rd);
      ecnt <= ecnt + CW'(do_wr && (|wr_flags)) - CW'(do_rd && head_err);
      if (wr_en && !do_wr)  ovr <= 1'b1;
      else if (lsr_rd_stb)  ovr <= 1'b0;
      if (do_rd || empty)   ack <= 1'b0;
      else if (lsr_rd_stb)  ack <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      prv <= '0;
      dlt <= '0;
    end else begin
      s1  <= modem_in;
      s2  <= s1;
      prv <= s2;
      dlt <= (msr_rd_stb ? '0 : dlt) | (s2 ^ prv);
    end
  end

  assign rd_data    = empty ? 8'h00 : head[7:0];
  assign lsr        = {ecnt != '0, 2'b00, hflags, ovr, !empty};
  assign msr        = {s2, dlt};
  assign data_avail = fifo_en ? (cnt >= trig_eff) : !empty;
  assign irq_ls     = ie_ls && ((head_err && !ack) || ovr);
  assign irq_ms     = ie_ms && (|dlt);
endmodule

module rx_err_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_data_stb,
  input logic       lsr_rd_stb,
  input logic       full,
  input logic [7:0] lsr,
  input logic       data_avail,
  input logic       irq_ls
);
  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_data_stb |=> lsr[1]);
  // R5
  ls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd_stb && !wr_en && !rd_data_stb |=> !irq_ls);
  // R4
  ls_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] && !lsr[1] |-> !irq_ls);
  // R6
  err_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lsr[4:2]) |-> lsr[7]);
  // R8
  avail_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> lsr[0]);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data_stb(rd_data_stb),
  .lsr_rd_stb(lsr_rd_stb), .full(full), .lsr(lsr),
  .data_avail(data_avail), .irq_ls(irq_ls)
);

// File: tb/tb_rx_err_fifo.sv
`timescale 1ns/1ps
module tb_rx_err_fifo;
  localparam int DEPTH = 16;
  localparam int MW = 4;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_par_err = 0, wr_frm_err = 0, wr_brk = 0;
  logic [7:0] wr_data = 0;
  logic fifo_en = 1, ie_ls = 1, ie_ms = 1;
  logic [CW-1:0] trig_lvl = 1;
  logic rd_data_stb = 0, lsr_rd_stb = 0, msr_rd_stb = 0;
  logic [MW-1:0] modem_in = 0;
  logic [7:0] rd_data, lsr;
  logic [2*MW-1:0] msr;
  logic data_avail, irq_ls, irq_ms;
  int total = 0, fails = 0;

  rx_err_fifo #(.DEPTH(DEPTH), .MW(MW)) dut (.*);

  always #2.5 clk = ~clk;

  // {brk, frm, par, data}
  localparam logic [10:0] VEC [6] = '{
    {3'b000, 8'h41}, {3'b001, 8'h42}, {3'b000, 8'h43},
    {3'b010, 8'h44}, {3'b100, 8'h45}, {3'b000, 8'h46}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] f);
    wr_en = 1; wr_data = d; {wr_brk, wr_frm_err, wr_par_err} = f;
    @(negedge clk);
    wr_en = 0; {wr_brk, wr_frm_err, wr_par_err} = 0;
  endtask

  task automatic pop();
    rd_data_stb = 1; @(negedge clk); rd_data_stb = 0;
  endtask

  task automatic rd_lsr();
    lsr_rd_stb = 1; @(negedge clk); lsr_rd_stb = 0;
  endtask

  task automatic rd_msr();
    msr_rd_stb = 1; @(negedge clk); msr_rd_stb = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 lsr", lsr, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irqs/avail", {irq_ls, irq_ms, data_avail}, 0);

    for (int i = 0; i < 6; i++) wr(VEC[i][7:0], VEC[i][10:8]);
    for (int i = 0; i < 6; i++) begin
      automatic int left = 0;
      for (int j = i; j < 6; j++) if (VEC[j][10:8] != 0) left++;
      chk("R2 data order", rd_data, VEC[i][7:0]);
      chk("R2 ready", lsr[0], 1);
      chk("R3 head tags", lsr[4:2], VEC[i][10:8]);
      chk("R4 irq_ls follows head", irq_ls, VEC[i][10:8] != 0);
      chk("R6 summary", lsr[7], left != 0);
      pop();
    end
    chk("R3 empty tags", lsr, 0);

    // R5 re-arm
    wr(8'h11, 3'b000); wr(8'h22, 3'b001); wr(8'h33, 3'b010);
    chk("R4 clean head no irq", irq_ls, 0);
    chk("R6 summary behind clean head", lsr[7], 1);
    pop();
    chk("R5 tagged head irq", irq_ls, 1);
    rd_lsr();
    chk("R5 cleared by lsr read", irq_ls, 0);
    repeat (3) @(negedge clk);
    chk("R5 stays clear same head", irq_ls, 0);
    pop();
    chk("R5 rearm next tagged", {irq_ls, rd_data}, {1'b1, 8'h33});
    ie_ls = 0; @(negedge clk);
    chk("R11 ls gated", irq_ls, 0);
    ie_ls = 1; @(negedge clk);
    chk("R11 ls pending kept", irq_ls, 1);
    pop();
    chk("R6 summary cleared", lsr[7], 0);

    // R7 overrun
    for (int i = 0; i < DEPTH; i++) wr(8'(i), 3'b000);
    chk("R7 no overrun at full", lsr[1], 0);
    wr(8'hAA, 3'b000);
    chk("R7 overrun set", {lsr[1], irq_ls}, 2'b11);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R7 last kept byte", rd_data, 8'(DEPTH - 1));
      pop();
    end
    chk("R7 extra byte discarded", lsr[0], 0);
    chk("R7 overrun sticky", lsr[1], 1);
    rd_lsr();
    chk("R7 overrun cleared", {lsr[1], irq_ls}, 0);

    // R8 trigger
    trig_lvl = 4;
    wr(1, 0); wr(2, 0); wr(3, 0);
    chk("R8 below trigger", data_avail, 0);
    wr(4, 0);
    chk("R8 at trigger", data_avail, 1);
    repeat (3) pop();
    trig_lvl = 0; @(negedge clk);
    chk("R8 zero acts as one", data_avail, 1);
    pop();
    chk("R8 empty", data_avail, 0);
    trig_lvl = 1;

    // R9 holding register
    fifo_en = 0;
    wr(8'h55, 0);
    chk("R9 held", {data_avail, rd_data}, {1'b1, 8'h55});
    wr(8'h66, 0);
    chk("R9 overrun", {lsr[1], rd_data}, {1'b1, 8'h55});
    pop();
    chk("R9 empty after pop", {lsr[0], data_avail}, 0);
    rd_lsr();
    wr(8'h77, 3'b100);
    chk("R9 break tag irq", {lsr[4], irq_ls}, 2'b11);
    pop();
    fifo_en = 1;

    // R10 / R11 modem
    modem_in = 4'b0100;
    repeat (4) @(negedge clk);
    chk("R10 change latched", msr, 8'b0100_0100);
    chk("R10 irq_ms", irq_ms, 1);
    rd_msr();
    chk("R10 cleared by read", {msr[3:0], irq_ms}, 0);
    ie_ms = 0;
    modem_in = 4'b0101;
    repeat (4) @(negedge clk);
    chk("R11 ms gated", irq_ms, 0);
    chk("R11 change still latched", msr[3:0], 4'b0001);
    ie_ms = 1; @(negedge clk);
    chk("R11 ms pending kept", irq_ms, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule